// File: doc/BRIEF.md
# Character display host register interface

This block is the host-facing register and RAM access engine of a small character display controller. A host reaches it through an 8-bit data bus with a register-select input, a read/write input and a one-cycle enable strobe. Inside are a write-only instruction register and a data register. There is also a 7-bit address counter, a busy timer, a display RAM of one character code per position and a character pattern RAM.

Instruction writes can load the address counter, and the same instruction picks which RAM later data accesses use. Other instructions set the counting direction or clear the display. Data writes go through the data register into the selected RAM. Data reads come from the data register, which is refilled from the RAM on its own after every address set, read and clear. Each access is followed by a busy interval, and the host polls a status word to see when it ends. Strobes that arrive while the block is busy have no effect.

Top module: `chr_host_regs`

## Requirements
- R1: After reset the status word reads 0x00, data accesses target the display RAM, the direction is increment, every display RAM byte is 0x20, every pattern RAM byte is 0x00 and the data register is 0x00.
- R2: With host_rs=0, host_rdata is the status word: bit 7 is the busy flag and bits 6..0 are the address counter. The instruction register is never returned.
- R3: An accepted instruction with bit 7 set loads the address counter with bits 3..0, which are the low log2(DD_DEPTH) bits, and selects the display RAM. The byte at that address is then loaded into the data register.
- R4: An accepted instruction with bits 7..6 = 01 loads the address counter with bits 5..0, which are the low log2(CG_DEPTH) bits, and selects the pattern RAM. The byte at that address is then loaded into the data register.
- R5: An accepted data write (host_rs=1, host_rw=0) stores host_wdata at the current address of the selected RAM and also places it in the data register. The address counter then advances.
- R6: An accepted data read (host_rs=1, host_rw=1) returns the data register on host_rdata during the strobe cycle. The address counter then advances, and the byte at the new address is loaded into the data register.
- R7: The instruction 0000_01ds sets the direction, where d=1 means increment and d=0 means decrement. Advancing wraps modulo DD_DEPTH (16) for the display RAM and modulo CG_DEPTH (64) for the pattern RAM.
- R8: The instruction 0x01 fills the display RAM with 0x20, sets the address counter to 0 and selects the display RAM. It then loads the data register with 0x20.
- R9: The busy flag stays 1 for exactly OP_CYC (4) cycles after each accepted data write, data read, address set or direction instruction, and for CLR_CYC (64) cycles after a clear. The instruction codes 0x00, 0x02, 0x03 and 0x08..0x3F have no effect and start no busy interval.
- R10: While the busy flag is 1, every strobe is ignored. The address counter, the RAMs and the direction stay as they were.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_en | input | 1 | One-cycle access strobe |
| host_rs | input | 1 | 0 selects the instruction/status side, 1 selects data |
| host_rw | input | 1 | 0 means write, 1 means read |
| host_wdata | input | 8 | Write data or instruction code |
| host_rdata | output | 8 | Status word or data register, chosen by host_rs |

## Verification
The assertions check the following on every cycle:
- The busy timer counts down by exactly one.
- Every accepted strobe raises the busy flag.
- The address counter does not move while busy.
- A counter aimed at the display RAM never leaves its 16 positions.
- A counter aimed at the pattern RAM never leaves its 64 positions.

Only the bench's scenarios can show the following:
- The prefetched byte appears after an address set, a read or a clear.
- Busy lasts the right length for each kind of access.
- Both wrap directions hold at address 0.
- Strobes arriving during busy change nothing, as read back through the data path.

// File: rtl/chr_pkg.sv
package chr_pkg;

   typedef enum logic [2:0] {
      OPK_NONE,
      OPK_CLEAR,
      OPK_DIR,
      OPK_SET_PAT,
      OPK_SET_DISP
   } opk_e;

   typedef enum logic {
      TGT_DISP = 1'b0,
      TGT_PAT  = 1'b1
   } tgt_e;

   // classify an instruction byte by its highest set bit
   function automatic opk_e classify(input logic [7:0] code);
      opk_e k;
      casez (code)
         8'b1???_????: k = OPK_SET_DISP;
         8'b01??_????: k = OPK_SET_PAT;
         8'b0000_01??: k = OPK_DIR;
         8'b0000_0001: k = OPK_CLEAR;
         default:      k = OPK_NONE;
      endcase
      return k;
   endfunction

endpackage

// File: rtl/chr_instr_dec.sv
module chr_instr_dec
   import chr_pkg::*;
#(
   parameter int AC_W = 7
) (
   input  logic [7:0]      code,
   output opk_e            kind,
   output logic [AC_W-1:0] addr_field,
   output logic            dir_inc
);
   if (AC_W != 7) begin : g_bad_acw
      $error("chr_instr_dec: AC_W must be 7");
   end

   always_comb begin
      kind       = classify(code);
      addr_field = code[AC_W-1:0];
      dir_inc    = code[1];
   end
endmodule

// File: rtl/chr_busy_timer.sv
module chr_busy_timer #(
   parameter int CNT_W = 7
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [CNT_W-1:0] load_val,
   output logic             busy
);
   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk) begin
      if (!rst_n)
         cnt_q <= '0;
      else if (load)
         cnt_q <= load_val;
      else if (cnt_q != '0)
         cnt_q <= cnt_q - 1'b1;
   end

   assign busy = (cnt_q != '0);

   // R9: a running interval shrinks by exactly one per cycle
   assert_busy_count_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1));
endmodule

// File: rtl/chr_ram.sv
module chr_ram #(
   parameter int         DEPTH    = 16,
   parameter int         AW       = 4,
   parameter logic [7:0] RST_VAL  = 8'h00,
   parameter bit         HAS_FILL = 1'b0,
   parameter logic [7:0] FILL_VAL = 8'h20
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          we,
   input  logic [AW-1:0] waddr,
   input  logic [7:0]    wdata,
   input  logic          fill,
   input  logic [AW-1:0] raddr,
   output logic [7:0]    rdata
);
   if ((1 << AW) != DEPTH) begin : g_bad_depth
      $error("chr_ram: DEPTH must equal 2**AW");
   end

   logic [7:0] mem_q [DEPTH];

   if (HAS_FILL) begin : g_fill
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem_q[i] <= RST_VAL;
         end else if (fill) begin
            for (int i = 0; i < DEPTH; i++) mem_q[i] <= FILL_VAL;
         end else if (we) begin
            mem_q[waddr] <= wdata;
         end
      end
   end else begin : g_plain
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem_q[i] <= RST_VAL;
         end else if (we) begin
            mem_q[waddr] <= wdata;
         end
      end
      logic unused_fill;
      assign unused_fill = fill;
   end

   assign rdata = mem_q[raddr];
endmodule

// File: rtl/chr_host_regs.sv
module chr_host_regs
   import chr_pkg::*;
#(
   parameter int         DD_DEPTH = 16,
   parameter int         CG_DEPTH = 64,
   parameter int         OP_CYC   = 4,
   parameter int         CLR_CYC  = 64,
   parameter logic [7:0] BLANK    = 8'h20
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       host_en,
   input  logic       host_rs,
   input  logic       host_rw,
   input  logic [7:0] host_wdata,
   output logic [7:0] host_rdata
);
   localparam int AC_W  = 7;
   localparam int DD_AW = $clog2(DD_DEPTH);
   localparam int CG_AW = $clog2(CG_DEPTH);
   localparam int MAXC  = (CLR_CYC > OP_CYC) ? CLR_CYC : OP_CYC;
   localparam int CNT_W = $clog2(MAXC + 1);
   localparam logic [AC_W-1:0] DD_MASK = AC_W'(DD_DEPTH - 1);
   localparam logic [AC_W-1:0] CG_MASK = AC_W'(CG_DEPTH - 1);

   if (OP_CYC < 2) begin : g_bad_op
      $error("chr_host_regs: OP_CYC must be at least 2 so the prefetch lands inside busy");
   end
   if (CLR_CYC < 2) begin : g_bad_clr
      $error("chr_host_regs: CLR_CYC must be at least 2");
   end
   if (DD_AW > AC_W || CG_AW > AC_W) begin : g_bad_ram
      $error("chr_host_regs: RAM depth exceeds address counter range");
   end

   // state
   logic [AC_W-1:0] ac_q;
   tgt_e            tgt_q;
   logic            inc_q;
   logic [7:0]      dr_q;
   logic            fetch_q;
   logic            busy;

   // decode
   opk_e            kind;
   logic [AC_W-1:0] addr_field;
   logic            dir_bit;

   chr_instr_dec #(.AC_W(AC_W)) u_dec (
      .code       (host_wdata),
      .kind       (kind),
      .addr_field (addr_field),
      .dir_inc    (dir_bit)
   );

   logic go, go_ins, go_wr, go_rd;
   assign go     = host_en && !busy;
   assign go_ins = go && !host_rs && !host_rw;
   assign go_wr  = go &&  host_rs && !host_rw;
   assign go_rd  = go &&  host_rs &&  host_rw;

   logic ins_live;
   assign ins_live = go_ins && (kind != OPK_NONE);

   // next address after a data access
   logic [AC_W-1:0] ac_step, ac_mask;
   always_comb begin
      ac_mask = (tgt_q == TGT_PAT) ? CG_MASK : DD_MASK;
      ac_step = (inc_q ? (ac_q + 1'b1) : (ac_q - 1'b1)) & ac_mask;
   end

   // RAMs
   logic [7:0] dd_rdata, cg_rdata;
   logic       dd_we, cg_we, clr_go;

   assign dd_we  = go_wr && (tgt_q == TGT_DISP);
   assign cg_we  = go_wr && (tgt_q == TGT_PAT);
   assign clr_go = go_ins && (kind == OPK_CLEAR);

   chr_ram #(
      .DEPTH    (DD_DEPTH),
      .AW       (DD_AW),
      .RST_VAL  (BLANK),
      .HAS_FILL (1'b1),
      .FILL_VAL (BLANK)
   ) u_dd (
      .clk   (clk),
      .rst_n (rst_n),
      .we    (dd_we),
      .waddr (ac_q[DD_AW-1:0]),
      .wdata (host_wdata),
      .fill  (clr_go),
      .raddr (ac_q[DD_AW-1:0]),
      .rdata (dd_rdata)
   );

   chr_ram #(
      .DEPTH    (CG_DEPTH),
      .AW       (CG_AW),
      .RST_VAL  (8'h00),
      .HAS_FILL (1'b0),
      .FILL_VAL (8'h00)
   ) u_cg (
      .clk   (clk),
      .rst_n (rst_n),
      .we    (cg_we),
      .waddr (ac_q[CG_AW-1:0]),
      .wdata (host_wdata),
      .fill  (1'b0),
      .raddr (ac_q[CG_AW-1:0]),
      .rdata (cg_rdata)
   );

   // busy timer
   logic             t_load;
   logic [CNT_W-1:0] t_val;
   assign t_load = go_wr || go_rd || ins_live;
   assign t_val  = (kind == OPK_CLEAR && go_ins) ? CNT_W'(CLR_CYC) : CNT_W'(OP_CYC);

   chr_busy_timer #(.CNT_W(CNT_W)) u_busy (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (t_load),
      .load_val (t_val),
      .busy     (busy)
   );

   // address counter, target, direction
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ac_q  <= '0;
         tgt_q <= TGT_DISP;
         inc_q <= 1'b1;
      end else if (go_wr || go_rd) begin
         ac_q <= ac_step;
      end else if (go_ins) begin
         case (kind)
            OPK_SET_DISP: begin
               ac_q  <= addr_field & DD_MASK;
               tgt_q <= TGT_DISP;
            end
            OPK_SET_PAT: begin
               ac_q  <= addr_field & CG_MASK;
               tgt_q <= TGT_PAT;
            end
            OPK_DIR:   inc_q <= dir_bit;
            OPK_CLEAR: begin
               ac_q  <= '0;
               tgt_q <= TGT_DISP;
            end
            default: ;
         endcase
      end
   end

   // data register and prefetch
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         dr_q    <= 8'h00;
         fetch_q <= 1'b0;
      end else begin
         fetch_q <= go_rd || (go_ins && (kind == OPK_SET_DISP ||
                                         kind == OPK_SET_PAT  ||
                                         kind == OPK_CLEAR));
         if (go_wr)
            dr_q <= host_wdata;
         else if (fetch_q)
            dr_q <= (tgt_q == TGT_PAT) ? cg_rdata : dd_rdata;
      end
   end

   assign host_rdata = host_rs ? dr_q : {busy, ac_q};

   // R9: every accepted access starts a busy interval
   assert_accept_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
      t_load |=> busy);
   // R10: nothing moves the counter while busy
   assert_hold_ac_R10: assert property (@(posedge clk) disable iff (!rst_n)
      busy |=> $stable(ac_q));
   // R7: display-targeted counter stays within the display RAM
   assert_dd_wrap_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (tgt_q == TGT_DISP) |-> ((ac_q & ~DD_MASK) == '0));
   // R7: pattern-targeted counter stays within the pattern RAM
   assert_cg_wrap_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (tgt_q == TGT_PAT) |-> ((ac_q & ~CG_MASK) == '0));
endmodule

// File: tb/sim_chr_host_regs.sv
module sim_chr_host_regs;
   localparam int OPC = 4;
   localparam int CLC = 64;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       host_en = 1'b0, host_rs = 1'b0, host_rw = 1'b0;
   logic [7:0] host_wdata = 8'h00;
   logic [7:0] host_rdata;

   always #2 clk = ~clk;

   chr_host_regs u0 (
      .clk(clk), .rst_n(rst_n), .host_en(host_en), .host_rs(host_rs),
      .host_rw(host_rw), .host_wdata(host_wdata), .host_rdata(host_rdata)
   );

   int checks = 0;
   int errors = 0;

   // reference model
   logic [7:0] m_dd [16];
   logic [7:0] m_cg [64];
   logic [6:0] m_ac;
   logic       m_pat;
   logic       m_inc;
   logic [7:0] m_dr;

   task automatic chk(input bit ok, input string req, input logic [7:0] act, input logic [7:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
      end
   endtask

   function automatic logic [6:0] step(input logic [6:0] a, input logic pat, input logic inc);
      logic [6:0] n;
      n = inc ? a + 7'd1 : a - 7'd1;
      return pat ? (n & 7'h3F) : (n & 7'h0F);
   endfunction

   function automatic logic [7:0] mem_at(input logic [6:0] a, input logic pat);
      return pat ? m_cg[a[5:0]] : m_dd[a[3:0]];
   endfunction

   // expected busy length of an instruction code
   function automatic int ins_len(input logic [7:0] c);
      if (c[7] || c[7:6] == 2'b01 || c[7:2] == 6'b000001) return OPC;
      if (c == 8'h01) return CLC;
      return 0;
   endfunction

   task automatic strobe(input logic rs, input logic rw, input logic [7:0] d, output logic [7:0] rd);
      @(negedge clk);
      host_en = 1'b1; host_rs = rs; host_rw = rw; host_wdata = d;
      #1 rd = host_rdata;
      @(negedge clk);
      host_en = 1'b0; host_rs = 1'b0; host_rw = 1'b0;
   endtask

   task automatic wait_idle(output int n);
      n = 0;
      #1;
      while (host_rdata[7] && n < 1000) begin
         n++;
         @(negedge clk);
         #1;
      end
   endtask

   // perform one access, update model, check busy length and status
   task automatic op(input logic rs, input logic rw, input logic [7:0] d, input string req);
      logic [7:0] rd;
      int n, exp_n;
      strobe(rs, rw, d, rd);
      exp_n = OPC;
      if (rs && !rw) begin
         if (m_pat) m_cg[m_ac[5:0]] = d; else m_dd[m_ac[3:0]] = d;
         m_dr = d;
         m_ac = step(m_ac, m_pat, m_inc);
      end else if (rs && rw) begin
         chk(rd == m_dr, {req, " R6 read data"}, rd, m_dr);
         m_ac = step(m_ac, m_pat, m_inc);
         m_dr = mem_at(m_ac, m_pat);
      end else begin
         exp_n = ins_len(d);
         if (d[7]) begin
            m_ac = {3'b000, d[3:0]}; m_pat = 1'b0; m_dr = mem_at(m_ac, m_pat);
         end else if (d[7:6] == 2'b01) begin
            m_ac = {1'b0, d[5:0]}; m_pat = 1'b1; m_dr = mem_at(m_ac, m_pat);
         end else if (d[7:2] == 6'b000001) begin
            m_inc = d[1];
         end else if (d == 8'h01) begin
            for (int i = 0; i < 16; i++) m_dd[i] = 8'h20;
            m_ac = 7'd0; m_pat = 1'b0; m_dr = 8'h20;
         end
      end
      wait_idle(n);
      chk(n == exp_n, {req, " R9 busy length"}, 8'(n), 8'(exp_n));
      chk(host_rdata == {1'b0, m_ac}, {req, " R2 status"}, host_rdata, {1'b0, m_ac});
   endtask

   task automatic peek_dr(input string req);
      host_rs = 1'b1;
      #1 chk(host_rdata == m_dr, {req, " data register"}, host_rdata, m_dr);
      host_rs = 1'b0;
   endtask

   initial begin
      #(4 * 150000);
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      logic [7:0] rd;
      int n;
      void'($urandom(32'd1234));
      for (int i = 0; i < 16; i++) m_dd[i] = 8'h20;
      for (int i = 0; i < 64; i++) m_cg[i] = 8'h00;
      m_ac = 7'd0; m_pat = 1'b0; m_inc = 1'b1; m_dr = 8'h00;

      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      #1 chk(host_rdata == 8'h00, "R1 reset status", host_rdata, 8'h00);
      peek_dr("R1 reset");
      op(1'b0, 1'b0, 8'h83, "R3 set disp 3");
      peek_dr("R1 R3 prefetch blank");
      op(1'b0, 1'b0, 8'h45, "R4 set pat 5");
      peek_dr("R1 R4 prefetch zero");

      // R5 write then read back
      op(1'b1, 1'b0, 8'hA5, "R5 write pat");
      op(1'b0, 1'b0, 8'h45, "R4 reset pat 5");
      peek_dr("R5 R4 readback");
      op(1'b1, 1'b1, 8'h00, "R6 read pat 5");

      // R7 decrement wrap on display RAM
      op(1'b0, 1'b0, 8'h04, "R7 dir decrement");
      op(1'b0, 1'b0, 8'h80, "R3 set disp 0");
      op(1'b1, 1'b0, 8'h11, "R7 write at 0");
      chk(host_rdata == 8'h0F, "R7 disp wrap to 15", host_rdata, 8'h0F);
      op(1'b0, 1'b0, 8'h40, "R4 set pat 0");
      op(1'b1, 1'b1, 8'h00, "R7 read pat 0");
      chk(host_rdata == 8'h3F, "R7 pat wrap to 63", host_rdata, 8'h3F);
      op(1'b0, 1'b0, 8'h06, "R7 dir increment");
      op(1'b0, 1'b0, 8'hBF, "R3 set disp masked");
      op(1'b1, 1'b1, 8'h00, "R7 read disp 15");
      chk(host_rdata == 8'h00, "R7 disp wrap to 0", host_rdata, 8'h00);

      // R9 no-op codes
      op(1'b0, 1'b0, 8'h10, "R9 noop 10");
      op(1'b0, 1'b0, 8'h02, "R9 noop 02");
      op(1'b0, 1'b0, 8'h00, "R9 noop 00");

      // R10 strobes during busy are ignored
      op(1'b0, 1'b0, 8'h82, "R10 set disp 2");
      strobe(1'b1, 1'b0, 8'h77, rd);           // accepted write, now busy
      if (m_pat) m_cg[m_ac[5:0]] = 8'h77; else m_dd[m_ac[3:0]] = 8'h77;
      m_dr = 8'h77;
      m_ac = step(m_ac, m_pat, m_inc);
      strobe(1'b0, 1'b0, 8'h8A, rd);           // ignored address set
      strobe(1'b1, 1'b0, 8'h99, rd);           // ignored write
      wait_idle(n);
      chk(host_rdata == {1'b0, m_ac}, "R10 counter unchanged", host_rdata, {1'b0, m_ac});
      peek_dr("R10");
      op(1'b0, 1'b0, 8'h83, "R10 set disp 3");
      peek_dr("R10 untouched byte");
      op(1'b0, 1'b0, 8'h82, "R10 set disp 2");
      peek_dr("R10 stored byte");

      // random mix
      for (int k = 0; k < 400; k++) begin
         int r;
         r = int'($urandom % 10);
         case (r)
            0, 1, 2: op(1'b1, 1'b0, 8'($urandom), "R5 rand write");
            3, 4, 5: op(1'b1, 1'b1, 8'h00, "R6 rand read");
            6: op(1'b0, 1'b0, {1'b1, 7'($urandom)}, "R3 rand set disp");
            7: op(1'b0, 1'b0, {2'b01, 6'($urandom)}, "R4 rand set pat");
            8: op(1'b0, 1'b0, {6'b000001, 2'($urandom)}, "R7 rand dir");
            default: op(1'b0, 1'b0, ($urandom % 16 == 0) ? 8'h01 : 8'h20, "R8 R9 rand clr/noop");
         endcase
      end

      // R8 clear then full read back
      op(1'b0, 1'b0, 8'h01, "R8 clear");
      peek_dr("R8 prefetch");
      op(1'b0, 1'b0, 8'h06, "R8 dir inc");
      for (int i = 0; i < 16; i++) begin
         strobe(1'b1, 1'b1, 8'h00, rd);
         chk(rd == 8'h20, "R8 blank readback", rd, 8'h20);
         wait_idle(n);
      end

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule